// File: doc/BRIEF.md
# PHY Management Serial Master

This block drives the two-wire serial management bus used to configure Ethernet PHYs: a clock line it generates itself and a bidirectional data line. Software sets up the clock divider and the preamble option in a control register. It then writes a single 32-bit command word that packs the frame type, the PHY and register addresses, the turnaround pattern and any write data.

That one write launches the frame. The block shifts the word out MSB first. For a read it releases the data line and captures the PHY's 16-bit reply into the low half of the same command register. At the end of every frame it raises a sticky completion flag, which software clears by writing a one. The data line is driven through an output and an output enable. An external pull-up holds it high whenever the block is not driving it.

Register port: address 0 is control, address 1 is command/data and address 2 is completion. Writes are single-cycle strobes and reads are combinational.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are low and `irq` is low. The control register (address 0) reads 0x0000009F: divider 0x1f in bits 6:0, preamble enable 1 in bit 7, busy 0 in bit 8. The command register (address 1) reads 0.
- R2: While a frame runs, `mdc` starts low and toggles every (divider+1) clocks, where the divider is control bits 6:0. It never rises outside a frame.
- R3: With control bit 7 set, a frame begins with 32 bit times of logic one. With bit 7 clear, the frame starts directly with command bit 31.
- R4: After any preamble, command bits 31 down to 0 are presented MSB first, one per MDC period. The first bit is presented at launch and each later bit at a falling MDC edge. `mdio_o` changes at no other time inside a frame.
- R5: A frame whose command bits 29:28 are not 2'b10 (for example nibble 0x5, a write) keeps `mdio_oe` high for every bit of the frame.
- R6: A frame whose command bits 29:28 are 2'b10 (nibble 0x6, a read) drives bits 31 to 17 and holds `mdio_oe` low from command bit 16 to the end of the frame.
- R7: In a read frame, `mdio_i` is sampled at each rising MDC edge of command bits 15 to 0. The 16 samples, first one in bit 15, replace bits 15:0 of the command register when the frame ends. Bits 31:16 keep the written value.
- R8: At the clock edge that ends a frame, bit 0 of the completion register (address 2) and `irq` become 1 and stay 1. Writing 1 to bit 0 clears them. Writing 0 has no effect. A frame ending in the same cycle as a clear wins.
- R9: A write to the command register while a frame is in progress is ignored: the running frame continues unchanged and the register keeps its value.
- R10: Control bit 8 reads 1 from the edge after a command write is accepted until the frame ends.
- R11: Outside a frame, `mdio_oe` and `mdc` are low and `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 command, 2 completion) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Sticky frame-complete flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Everything is timed from the edge that accepts the command write; call it L and let h be the divider plus one. Frame bit k appears at L+2hk, its rising MDC edge comes at L+2hk+h, and the completion flag and the busy drop come together at L+2hN for an N-bit frame. The bench models this with a behavioural model that updates at every rising clock edge from the same inputs. It compares `mdc`, `mdio_oe`, the driven `mdio_o` and `irq` at every falling clock edge, so a result one cycle early or late fails in that cycle. Register reads are combinational and are checked one time step after the address changes, half a clock away from any edge.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared register selector and field positions for the
// management master. Assumes a 2-bit register address.
package mdio_mgmt_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DONE = 2'd2
    } reg_sel_e;

    // Command bits 29:28 equal to this value mark a read frame.
    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: management clock generator. Counts system clocks while a frame
// runs and toggles mdc every (div+1) clocks. It flags the edges where mdc
// is about to rise or fall. Assumes div stays stable during a frame.
module mdio_mdc_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             hit;

    assign hit  = run && (cnt_q == div);
    assign rise = hit && !mdc_q;
    assign fall = hit && mdc_q;
    assign mdc  = mdc_q;

    // Half-period counter and clock toggle; held low and cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
// Module: frame shifter. At launch it loads an optional all-ones preamble
// and the command word, shifts one bit per falling mdc edge, releases the
// line for the reply part of a read, and captures reply bits on rising
// edges. Assumes launch is only asserted while not busy.
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
#(
    parameter int CMD_W   = 32,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              pre_en,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FR_W    = PRE_LEN + CMD_W;
    localparam int CNT_W   = $clog2(FR_W + 1);
    localparam int REL_IDX = CMD_W - 1 - DATA_W;
    localparam int CAP_IDX = CMD_W - DATA_W;

    logic [FR_W-1:0]   sh_q;
    logic [CNT_W-1:0]  bit_q;
    logic              busy_q, pre_q, rd_q;
    logic [DATA_W-1:0] cap_q;
    logic [CNT_W-1:0]  last_bit, rel_at, cap_at;

    assign last_bit = pre_q ? CNT_W'(FR_W - 1) : CNT_W'(CMD_W - 1);
    assign rel_at   = pre_q ? CNT_W'(PRE_LEN + REL_IDX) : CNT_W'(REL_IDX);
    assign cap_at   = pre_q ? CNT_W'(PRE_LEN + CAP_IDX) : CNT_W'(CAP_IDX);

    assign busy    = busy_q;
    assign mdio_o  = busy_q ? sh_q[FR_W-1] : 1'b1;
    assign mdio_oe = busy_q && !(rd_q && (bit_q >= rel_at));
    assign done    = busy_q && fall && (bit_q == last_bit);
    assign rd_data = cap_q;

    // Frame load, bit advance on falling mdc, and end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            pre_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else if (launch) begin
            sh_q   <= pre_en ? {{PRE_LEN{1'b1}}, cmd} : {cmd, {PRE_LEN{1'b0}}};
            bit_q  <= '0;
            busy_q <= 1'b1;
            pre_q  <= pre_en;
            rd_q   <= (cmd[CMD_W-3:CMD_W-4] == OP_READ);
        end else if (busy_q && fall) begin
            if (bit_q == last_bit) begin
                busy_q <= 1'b0;
            end else begin
                bit_q <= bit_q + CNT_W'(1);
                sh_q  <= {sh_q[FR_W-2:0], 1'b0};
            end
        end
    end

    // Reply capture on rising mdc during the data part of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (busy_q && rise && rd_q && (bit_q >= cap_at)) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management master. Holds the control, command and
// completion registers, decodes the register port, and joins the clock
// generator and frame shifter. Assumes single-cycle write strobes.
module mdio_master
    import mdio_mgmt_pkg::*;
#(
    parameter int             DIV_W     = 7,
    parameter logic [DIV_W-1:0] DIV_RESET = 7'h1f,
    parameter logic           PRE_RESET = 1'b1,
    parameter int             CMD_W     = 32,
    parameter int             DATA_W    = 16,
    parameter int             PRE_LEN   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int PAD_W = CMD_W - DIV_W - 2;

    logic [DIV_W-1:0]  div_q;
    logic              pre_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              done_q;
    logic              busy, launch, done, rise, fall, is_rd;
    logic [DATA_W-1:0] rd_data;

    assign launch = reg_wr && (reg_addr == SEL_CMD) && !busy;
    assign is_rd  = (cmd_q[CMD_W-3:CMD_W-4] == OP_READ);
    assign irq    = done_q;

    // Control register: divider and preamble enable, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RESET;
            pre_q <= PRE_RESET;
        end else if (reg_wr && (reg_addr == SEL_CTRL)) begin
            div_q <= reg_wdata[DIV_W-1:0];
            pre_q <= reg_wdata[DIV_W];
        end
    end

    // Command register: loaded on an accepted write, reply merged at read end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (launch) begin
            cmd_q <= reg_wdata[CMD_W-1:0];
        end else if (done && is_rd) begin
            cmd_q[DATA_W-1:0] <= rd_data;
        end
    end

    // Completion flag: set at frame end, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done) begin
            done_q <= 1'b1;
        end else if (reg_wr && (reg_addr == SEL_DONE) && reg_wdata[0]) begin
            done_q <= 1'b0;
        end
    end

    // Read multiplexer for the register port.
    always_comb begin
        case (reg_addr)
            SEL_CTRL: reg_rdata = {{PAD_W{1'b0}}, busy, pre_q, div_q};
            SEL_CMD:  reg_rdata = cmd_q;
            SEL_DONE: reg_rdata = {31'd0, done_q};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (launch),
        .div     (div_q),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame_eng #(.CMD_W(CMD_W), .PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .cmd     (reg_wdata[CMD_W-1:0]),
        .pre_en  (pre_q),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: property checker for the management master, bound to the top.
// Assumes reset is held for at least one clock edge at start.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        w1c,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        irq,
    input logic        busy,
    input logic [15:0] cmd_hi
);
    // R2: the management clock only rises inside a frame.
    assert_mdc_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(busy));

    // R4: within a frame the data output moves only at a falling mdc edge.
    assert_shift_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    // R8: the completion flag is sticky until a write of one.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == 2'd2 && w1c)) |=> irq);

    // R8: the completion flag rises only as a frame ends.
    assert_flag_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R9: a command write during a frame leaves the upper command bits alone.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd1) |=> $stable(cmd_hi));

    // R11: idle means no drive and a low management clock.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .w1c      (reg_wdata[0]),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .irq      (irq),
    .busy     (busy),
    .cmd_hi   (cmd_q[31:16])
);

// File: tb/mdio_master_tb.sv
// Bench: behavioural cycle model of the management master, compared with
// the outputs at every falling clock edge, plus directed register checks.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Reference model state.
    int          m_div, m_cnt, m_bit, m_nb, m_pl;
    logic        m_pre, m_busy, m_mdc, m_rd, m_done, m_was, m_end;
    logic [63:0] m_frame;
    logic [31:0] m_cmd;
    logic [15:0] m_cap;
    logic [15:0] phy_word = 16'h0000;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Model: advance one clock with the same inputs the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 31; m_pre = 1'b1; m_cmd = '0; m_done = 1'b0; m_busy = 1'b0;
            m_mdc = 1'b0; m_cnt = 0; m_bit = 0; m_nb = 0; m_pl = 0; m_rd = 1'b0;
            m_cap = '0; m_frame = '0;
        end else begin
            m_was = m_busy;
            m_end = 1'b0;
            if (m_busy) begin
                if (m_cnt == m_div) begin
                    m_cnt = 0;
                    if (!m_mdc) begin
                        m_mdc = 1'b1;
                        if (m_rd && m_bit >= m_pl + 16) m_cap = {m_cap[14:0], mdio_i};
                    end else begin
                        m_mdc = 1'b0;
                        if (m_bit == m_nb - 1) begin
                            m_busy = 1'b0;
                            m_end = 1'b1;
                            if (m_rd) m_cmd[15:0] = m_cap;
                        end else begin
                            m_bit++;
                        end
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (reg_wr) begin
                if (reg_addr == 2'd0) begin
                    m_div = int'(reg_wdata[6:0]);
                    m_pre = reg_wdata[7];
                end else if (reg_addr == 2'd1 && !m_was) begin
                    m_cmd = reg_wdata; m_busy = 1'b1; m_cnt = 0; m_mdc = 1'b0; m_bit = 0;
                    m_rd = (reg_wdata[29:28] == 2'b10);
                    m_pl = m_pre ? 32 : 0;
                    m_nb = m_pl + 32;
                    m_frame = m_pre ? {32'hFFFF_FFFF, reg_wdata} : {reg_wdata, 32'd0};
                end else if (reg_addr == 2'd2 && reg_wdata[0]) begin
                    m_done = 1'b0;
                end
            end
            if (m_end) m_done = 1'b1;
        end
    end

    // Per-cycle comparison and PHY reply drive, away from the active edge.
    always @(negedge clk) begin
        logic exp_oe;
        if (rst_n) begin
            exp_oe = m_busy && !(m_rd && m_bit >= m_pl + 15);
            chk(mdc == m_mdc, "R2", "mdc", {31'd0, mdc}, {31'd0, m_mdc});
            chk(mdio_oe == exp_oe, m_rd ? "R6" : "R5", "mdio_oe",
                {31'd0, mdio_oe}, {31'd0, exp_oe});
            if (m_busy)
                chk(mdio_o == m_frame[63 - m_bit], (m_bit < m_pl) ? "R3" : "R4",
                    "mdio_o", {31'd0, mdio_o}, {31'd0, m_frame[63 - m_bit]});
            else
                chk(mdio_o == 1'b1 && !mdc, "R11", "idle mdio_o", {31'd0, mdio_o}, 32'd1);
            chk(irq == m_done, "R8", "irq", {31'd0, irq}, {31'd0, m_done});
        end
        if (m_busy && m_rd && m_bit >= m_pl + 16)
            mdio_i = phy_word[15 - (m_bit - m_pl - 16)];
        else
            mdio_i = 1'b1;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, "reg_rdata", reg_rdata, exp);
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [31:0] CMD_WR1 = {4'h5, 5'h03, 5'h04, 2'b10, 16'hA5C3};
    localparam logic [31:0] CMD_RD1 = {4'h6, 5'h01, 5'h02, 2'b10, 16'h0000};
    localparam logic [31:0] CMD_RD2 = {4'h6, 5'h1F, 5'h11, 2'b10, 16'hFFFF};
    localparam logic [31:0] CMD_WR2 = {4'h5, 5'h10, 5'h1E, 2'b10, 16'h0F0F};

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports and in the registers.
        rd_chk(2'd0, 32'h0000_009F, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        rd_chk(2'd2, 32'h0, "R1");
        chk(!mdc && !mdio_oe && !irq, "R1", "pins after reset", {29'd0, mdc, mdio_oe, irq}, 32'd0);

        // Write frame with default divider and preamble.
        wr(2'd1, CMD_WR1);
        repeat (100) @(negedge clk);
        rd_chk(2'd0, 32'h0000_019F, "R10");
        wr(2'd1, CMD_RD2);                     // R9: ignored while busy
        rd_chk(2'd1, CMD_WR1, "R9");
        wait_idle();
        rd_chk(2'd0, 32'h0000_009F, "R10");
        rd_chk(2'd1, CMD_WR1, "R5");
        rd_chk(2'd2, 32'h1, "R8");
        wr(2'd2, 32'h0);                        // R8: writing zero keeps the flag
        rd_chk(2'd2, 32'h1, "R8");
        wr(2'd2, 32'h1);
        rd_chk(2'd2, 32'h0, "R8");

        // Read frame, divider 2, no preamble.
        wr(2'd0, 32'h0000_0002);
        phy_word = 16'hBEEF;
        wr(2'd1, CMD_RD1);
        wait_idle();
        rd_chk(2'd1, {CMD_RD1[31:16], 16'hBEEF}, "R7");
        rd_chk(2'd2, 32'h1, "R8");
        wr(2'd2, 32'h1);

        // Read frame, divider 0, with preamble.
        wr(2'd0, 32'h0000_0080);
        phy_word = 16'h1234;
        wr(2'd1, CMD_RD2);
        wait_idle();
        rd_chk(2'd1, {CMD_RD2[31:16], 16'h1234}, "R7");

        // Write frame, divider 0, no preamble; clear left pending meanwhile.
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, CMD_WR2);
        wait_idle();
        rd_chk(2'd1, CMD_WR2, "R5");
        rd_chk(2'd0, 32'h0000_0000, "R3");
        wr(2'd2, 32'h1);
        rd_chk(2'd2, 32'h0, "R8");
        chk(!mdio_oe && !mdc && mdio_o, "R11", "idle pins",
            {29'd0, mdio_oe, mdc, mdio_o}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule